// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block holds the byte registers of a real-time clock. A host reaches them through two ports. It writes a register number to an index port. Later reads and writes on a data port then act on the register that number selects. Ten byte registers keep the current time and the three alarm bytes. Two control registers fix the time base, the periodic rate and the data format. Two status registers always read as zero.

Only one time-base and rate setting is legal, and only one data format (binary values, 24-hour clock). Writes that ask for anything else are refused and raise a one-cycle error pulse. The update-in-progress bit of the first control register changes state on every read of that register, so software that polls it sees it both set and clear. A periodic tick counts system clock cycles and emits a one-cycle interrupt pulse at the end of each interval. The tick runs while the periodic-enable bit of the second control register is set. The start-up time comes from parameters, and the year can be stored either in binary or as two BCD digits.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with a value from 0x00 to 0x0D selects that register. A larger value leaves the selection unchanged and sets `err_o` high for the cycle after the write.
- R2: Registers 0 to 9 (seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, weekday, day of month, month, year) return on a read the last byte written to them, with no error.
- R3: After reset the time registers hold the parameter values. The month is stored as INIT_MON0+1, the weekday as INIT_WDAY0+1 (1 = Sunday), and the alarms as 0. The year is the value INIT_YEAR[7:0], or with YEAR_BCD set, (INIT_YEAR mod 100) as tens digit in bits 7:4 and units digit in bits 3:0.
- R4: Register 0x0A resets to 0x26. Bit 7 is update-in-progress, bits 6:4 are the divider and bits 3:0 are the rate. Each read returns the stored value with bit 7 inverted and keeps that inverted value, so the first read after reset returns 0xA6 and the next returns 0x26.
- R5: A data write to 0x0A is accepted only for the value 0x26, which also clears bit 7. Any other value is refused, leaves the register unchanged and pulses `err_o`.
- R6: Register 0x0B resets to 0x46. Bit 6 is periodic enable, bit 3 is square-wave enable, bit 2 is binary mode and bit 1 is 24-hour mode. A write is accepted only if the value with bits 6 and 3 cleared equals 0x06. Otherwise it is refused, leaves the register unchanged and pulses `err_o`.
- R7: While register 0x0B bit 6 is clear, `tick_irq` stays low. Setting it while it is clear restarts the tick count from zero. Writing it set while it is already set does not disturb the running count.
- R8: While enabled, `tick_irq` is high for exactly one cycle every TICK_CYCLES cycles. The first pulse comes TICK_CYCLES cycles after the enabling write edge, or TICK_CYCLES cycles after reset is released.
- R9: Reads of 0x0C and 0x0D return 0x00. Data writes to them are refused and pulse `err_o`.
- R10: `dat_rdata` takes the selected register's value at the edge where `dat_re` is sampled high, and otherwise holds its value, even when the register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Register number to select |
| dat_we | input | 1 | Data port write strobe to the selected register |
| dat_re | input | 1 | Data port read strobe from the selected register |
| dat_wdata | input | 8 | Data port write byte |
| dat_rdata | output | 8 | Registered read byte |
| err_o | output | 1 | One-cycle pulse after a refused index or data write |
| tick_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The bench sweeps all 256 index values, all 256 writes to each control register and every time byte. It checks them against a bench model of the selection, the acceptance rules and the toggling bit. A design that compared the index against the wrong limit would accept 0x0E or refuse 0x0D. A design with a slip in the masks would accept a wrong register-B byte, or refuse one whose only extra bits are the enable or square-wave bits. A design that did not keep the inverted update bit would return 0xA6 on every read, and one that toggled it on writes would drift away from the model. On the tick side, the bench measures the cycles from the enabling write to the first pulse and from one pulse to the next, and checks that no pulse occurs while the tick is disabled. It also rewrites the enable during a running interval, so a design that restarted its count on that write would fire late.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

    localparam int BYTE_W        = 8;
    localparam int NUM_TIME_REGS = 10;
    localparam int IDX_W         = 4;

    localparam logic [IDX_W-1:0] IDX_CTRL_A = 4'hA;
    localparam logic [IDX_W-1:0] IDX_CTRL_B = 4'hB;
    localparam logic [IDX_W-1:0] IDX_LAST   = 4'hD;

    localparam logic [BYTE_W-1:0] CTRL_A_RST   = 8'h26;
    localparam logic [BYTE_W-1:0] CTRL_B_RST   = 8'h46;
    localparam logic [BYTE_W-1:0] CTRL_B_FREE  = 8'h48;
    localparam logic [BYTE_W-1:0] CTRL_B_FIXED = 8'h06;

    typedef struct packed {
        logic       uip;
        logic [2:0] divider;
        logic [3:0] rate;
    } ctrl_a_t;

    typedef struct packed {
        logic rsvd7;
        logic pie;
        logic rsvd5;
        logic rsvd4;
        logic sqwe;
        logic bin_mode;
        logic hour24;
        logic rsvd0;
    } ctrl_b_t;

    function automatic logic [BYTE_W-1:0] year_code(int unsigned yr, bit bcd);
        int unsigned t;
        if (bcd) begin
            t = yr % 100;
            return BYTE_W'(((t / 10) << 4) | (t % 10));
        end
        return BYTE_W'(yr);
    endfunction

    function automatic logic [NUM_TIME_REGS*BYTE_W-1:0] reset_image(
        int unsigned sec, int unsigned mins, int unsigned hr, int unsigned wday0,
        int unsigned mday, int unsigned mon0, int unsigned yr, bit bcd);
        logic [NUM_TIME_REGS*BYTE_W-1:0] img;
        img = '0;
        img[0*BYTE_W +: BYTE_W] = BYTE_W'(sec);
        img[2*BYTE_W +: BYTE_W] = BYTE_W'(mins);
        img[4*BYTE_W +: BYTE_W] = BYTE_W'(hr);
        img[6*BYTE_W +: BYTE_W] = BYTE_W'(wday0 + 1);
        img[7*BYTE_W +: BYTE_W] = BYTE_W'(mday);
        img[8*BYTE_W +: BYTE_W] = BYTE_W'(mon0 + 1);
        img[9*BYTE_W +: BYTE_W] = year_code(yr, bcd);
        return img;
    endfunction

endpackage

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
    import rtc_regfile_pkg::*;
#(
    parameter int N = NUM_TIME_REGS,
    parameter logic [N*BYTE_W-1:0] RST_IMAGE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    sel,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [N*BYTE_W-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                q[i*BYTE_W +: BYTE_W] <= RST_IMAGE[i*BYTE_W +: BYTE_W];
            else if (we && sel == IDX_W'(i))
                q[i*BYTE_W +: BYTE_W] <= wdata;
        end
    end

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  sel,
    input  logic              we,
    input  logic              re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_val,
    output logic              reject,
    output logic              pie_en
);

    ctrl_a_t a_q;
    ctrl_b_t b_q;

    logic is_a, is_b, is_stat, a_ok, b_ok;

    always_comb begin
        is_a    = (sel == IDX_CTRL_A);
        is_b    = (sel == IDX_CTRL_B);
        is_stat = (sel > IDX_CTRL_B);
        a_ok    = (wdata == CTRL_A_RST);
        b_ok    = ((wdata & ~CTRL_B_FREE) == CTRL_B_FIXED);
        reject  = (is_a && !a_ok) || (is_b && !b_ok) || is_stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= ctrl_a_t'(CTRL_A_RST);
            b_q <= ctrl_b_t'(CTRL_B_RST);
        end else begin
            if (we && is_a && a_ok)
                a_q <= ctrl_a_t'(wdata);
            else if (re && is_a)
                a_q.uip <= ~a_q.uip;
            if (we && is_b && b_ok)
                b_q <= ctrl_b_t'(wdata);
        end
    end

    always_comb begin
        if (is_a)
            rd_val = {~a_q.uip, a_q.divider, a_q.rate};
        else if (is_b)
            rd_val = b_q;
        else
            rd_val = '0;
    end

    assign pie_en = b_q.pie;

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int PERIOD = 97656
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic pulse
);

    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            pulse <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int TICK_CYCLES = 97656,
    parameter int INIT_SEC    = 0,
    parameter int INIT_MIN    = 0,
    parameter int INIT_HOUR   = 0,
    parameter int INIT_WDAY0  = 0,
    parameter int INIT_MDAY   = 1,
    parameter int INIT_MON0   = 0,
    parameter int INIT_YEAR   = 100,
    parameter bit YEAR_BCD    = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] dat_wdata,
    output logic [7:0] dat_rdata,
    output logic       err_o,
    output logic       tick_irq
);

    localparam logic [NUM_TIME_REGS*BYTE_W-1:0] RST_IMAGE = reset_image(
        INIT_SEC, INIT_MIN, INIT_HOUR, INIT_WDAY0, INIT_MDAY, INIT_MON0,
        INIT_YEAR, YEAR_BCD);

    logic [IDX_W-1:0]                sel_q;
    logic [NUM_TIME_REGS*BYTE_W-1:0] time_q;
    logic [BYTE_W-1:0]               ctrl_rd, rd_mux;
    logic                            ctrl_reject, pie_en, idx_bad, in_time;

    assign idx_bad = (idx_wdata > {{(BYTE_W-IDX_W){1'b0}}, IDX_LAST});
    assign in_time = (sel_q < IDX_W'(NUM_TIME_REGS));

    rtc_time_bank #(.N(NUM_TIME_REGS), .RST_IMAGE(RST_IMAGE)) u_bank (
        .clk(clk), .rst(rst), .we(dat_we && in_time), .sel(sel_q),
        .wdata(dat_wdata), .q(time_q)
    );

    rtc_ctrl_regs u_ctrl (
        .clk(clk), .rst(rst), .sel(sel_q), .we(dat_we && !in_time),
        .re(dat_re), .wdata(dat_wdata), .rd_val(ctrl_rd),
        .reject(ctrl_reject), .pie_en(pie_en)
    );

    rtc_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .en(pie_en), .pulse(tick_irq)
    );

    always_comb begin
        if (in_time)
            rd_mux = time_q[sel_q*BYTE_W +: BYTE_W];
        else
            rd_mux = ctrl_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            dat_rdata <= '0;
            err_o     <= 1'b0;
        end else begin
            if (idx_we && !idx_bad)
                sel_q <= idx_wdata[IDX_W-1:0];
            if (dat_re)
                dat_rdata <= rd_mux;
            err_o <= (idx_we && idx_bad) || (dat_we && !in_time && ctrl_reject);
        end
    end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
    input logic       clk,
    input logic       rst,
    input logic       idx_we,
    input logic [7:0] idx_wdata,
    input logic       dat_re,
    input logic [3:0] sel_q,
    input logic [7:0] dat_rdata,
    input logic       err_o,
    input logic       tick_irq,
    input logic       pie_en
);

    assert_bad_index_flag_R1: assert property (@(posedge clk) disable iff (rst)
        (idx_we && idx_wdata > 8'h0D) |=> err_o);

    assert_bad_index_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (idx_we && idx_wdata > 8'h0D) |=> (sel_q == $past(sel_q)));

    assert_ctrl_a_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (dat_re && sel_q == 4'hA) |=> (dat_rdata[6:0] == 7'h26));

    assert_ctrl_b_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (dat_re && sel_q == 4'hB) |=> ((dat_rdata & 8'hB7) == 8'h06));

    assert_tick_off_R7: assert property (@(posedge clk) disable iff (rst)
        !pie_en |=> !tick_irq);

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
        tick_irq |=> !tick_irq);

    assert_status_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (dat_re && sel_q > 4'hB) |=> (dat_rdata == 8'h00));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !dat_re |=> $stable(dat_rdata));

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk(clk), .rst(rst), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_re(dat_re), .sel_q(sel_q), .dat_rdata(dat_rdata), .err_o(err_o),
    .tick_irq(tick_irq), .pie_en(pie_en)
);

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
module rtc_regfile_test;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] idx_wdata = '0, dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       err_o, tick_irq;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    logic [7:0] m [0:9];
    logic       uip;
    logic [7:0] bval;
    logic [7:0] rd_v;
    logic       e_v;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_regfile #(
        .TICK_CYCLES(N), .INIT_SEC(45), .INIT_MIN(30), .INIT_HOUR(23),
        .INIT_WDAY0(0), .INIT_MDAY(31), .INIT_MON0(11), .INIT_YEAR(123),
        .YEAR_BCD(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .err_o(err_o), .tick_irq(tick_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v, output logic e);
        idx_we = 1'b1; idx_wdata = v;
        @(posedge clk); @(negedge clk);
        idx_we = 1'b0;
        e = err_o;
    endtask

    task automatic wr_dat(input logic [7:0] v, output logic e);
        dat_we = 1'b1; dat_wdata = v;
        @(posedge clk); @(negedge clk);
        dat_we = 1'b0;
        e = err_o;
    endtask

    task automatic rd(output logic [7:0] v);
        dat_re = 1'b1;
        @(posedge clk); @(negedge clk);
        dat_re = 1'b0;
        v = dat_rdata;
    endtask

    // expected read value from the bench model; updates the toggling bit
    task automatic model_rd(input int idx, output logic [7:0] v);
        if (idx < 10) v = m[idx];
        else if (idx == 10) begin uip = ~uip; v = {uip, 7'h26}; end
        else if (idx == 11) v = bval;
        else v = 8'h00;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        logic [7:0] ev;
        int t0, t1, k, pulses;
        m[0] = 8'd45; m[1] = 0; m[2] = 8'd30; m[3] = 0; m[4] = 8'd23; m[5] = 0;
        m[6] = 8'd1; m[7] = 8'd31; m[8] = 8'd12; m[9] = 8'h23;
        uip = 1'b0; bval = 8'h46;

        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check(dat_rdata == 8'h00 && err_o == 1'b0, "R10 reset", dat_rdata, 0);

        // R3 R4 R6 R9: reset contents
        for (int i = 0; i < 14; i++) begin
            wr_idx(8'(i), e_v);
            rd(rd_v);
            model_rd(i, ev);
            check(rd_v == ev, i < 10 ? "R3 reset time" : "R4/R6/R9 reset ctrl", rd_v, ev);
        end

        // R1: every index value
        for (int v = 0; v < 256; v++) begin
            wr_idx(8'h05, e_v);
            wr_idx(8'(v), e_v);
            check(e_v == (v > 13), "R1 index err", e_v, v > 13);
            rd(rd_v);
            model_rd(v > 13 ? 5 : v, ev);
            check(rd_v == ev, "R1 index select", rd_v, ev);
        end

        // R2: write and read back every time byte, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 10; i++) begin
                wr_idx(8'(i), e_v);
                m[i] = 8'((i * 37 + 11) ^ (p * 255));
                wr_dat(m[i], e_v);
                check(e_v == 1'b0, "R2 write err", e_v, 0);
            end
            for (int i = 0; i < 10; i++) begin
                wr_idx(8'(i), e_v);
                rd(rd_v);
                check(rd_v == m[i], "R2 readback", rd_v, m[i]);
            end
        end

        // R4: consecutive reads toggle bit 7
        wr_idx(8'h0A, e_v);
        for (int i = 0; i < 4; i++) begin
            rd(rd_v);
            model_rd(10, ev);
            check(rd_v == ev, "R4 toggle", rd_v, ev);
        end

        // R5: every value written to register A
        for (int v = 0; v < 256; v++) begin
            wr_dat(8'(v), e_v);
            check(e_v == (v != 8'h26), "R5 accept", e_v, v != 8'h26);
            if (v == 8'h26) uip = 1'b0;
            rd(rd_v);
            model_rd(10, ev);
            check(rd_v == ev, "R5 value", rd_v, ev);
        end

        // R6: every value written to register B
        wr_idx(8'h0B, e_v);
        for (int v = 0; v < 256; v++) begin
            wr_dat(8'(v), e_v);
            check(e_v == ((v & 8'hB7) != 8'h06), "R6 accept", e_v, (v & 8'hB7) != 8'h06);
            if ((v & 8'hB7) == 8'h06) bval = 8'(v);
            rd(rd_v);
            check(rd_v == bval, "R6 value", rd_v, bval);
        end

        // R7: disabled tick is silent
        wr_dat(8'h06, e_v);
        pulses = 0;
        for (int i = 0; i < 4 * N; i++) begin
            @(negedge clk);
            if (tick_irq) pulses++;
        end
        check(pulses == 0, "R7 disabled", pulses, 0);

        // R8: first pulse N cycles after the enabling write
        wr_dat(8'h46, e_v);
        k = 0;
        do begin @(negedge clk); k++; end while (!tick_irq && k < 4 * N);
        check(k == N, "R8 first pulse", k, N);
        t0 = cyc;
        @(negedge clk);
        check(tick_irq == 1'b0, "R8 pulse width", tick_irq, 0);
        // R7: rewrite of enable while running keeps the count
        @(negedge clk); @(negedge clk);
        wr_dat(8'h4E, e_v);
        do @(negedge clk); while (!tick_irq && cyc - t0 < 4 * N);
        t1 = cyc;
        check(t1 - t0 == N, "R7 no restart", t1 - t0, N);
        do @(negedge clk); while (!tick_irq && cyc - t1 < 4 * N);
        check(cyc - t1 == N, "R8 period", cyc - t1, N);

        // R9: status writes refused
        for (int i = 12; i < 14; i++) begin
            wr_idx(8'(i), e_v);
            wr_dat(8'h55, e_v);
            check(e_v == 1'b1, "R9 write err", e_v, 1);
            rd(rd_v);
            check(rd_v == 8'h00, "R9 read zero", rd_v, 0);
        end

        // R10: output holds while the register changes without a read
        wr_idx(8'h03, e_v);
        rd(rd_v);
        wr_dat(8'hC3, e_v);
        repeat (3) @(negedge clk);
        check(dat_rdata == rd_v, "R10 hold", dat_rdata, rd_v);
        rd(rd_v);
        check(rd_v == 8'hC3, "R10 update", rd_v, 8'hC3);

        finish_run();
    end

endmodule